// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator Peripheral

This block is a polled, register-mapped source of pseudo-random numbers on a plain 32-bit read/write bus with a 9-bit byte address. Software loads five 32-bit seed words and sets two control bits: one selects the generator engine and the other requests a run. The block then steps a built-in 160-bit xorshift core five times and publishes the five words it draws as read-only result words. It reports progress in a status word that software polls.

A run is launched only when all five seed slots have been written since reset, the engine-select bit and the start bit are both set in the same control write, and no run is in progress. The start bit never reads back as one. Every run restarts the core from the seed words that are held at the moment of launch, so the same seeds always give the same five words.

Top module: `seedrng_periph`

## Requirements
- R1: After reset the control word reads 0x0, the status word reads 0x1, and all five result words read 0x0.
- R2: The map uses aligned byte offsets: control at 0x000, status at 0x010, seed slot k at 0x140+4k, result word k at 0x160+4k (k = 0..4). A read of any other offset, including a misaligned one or a seed slot, returns 0. A write to any other offset changes no state. The read data is 0 unless a read (select high, write low) is in progress.
- R3: Control bit 3 selects the engine and bit 4 requests a start. A control write stores the written value with bit 4 forced to 0, so the other bits read back as written.
- R4: Each seed slot has a written flag that its own write sets. Status bit 1 reads 1 only once all five flags are set, and only reset clears the flags.
- R5: A control write launches a run only if status bit 1 is set, written bit 3 is 1, and written bit 4 is 1. Otherwise nothing starts.
- R6: Status bit 2 (busy) reads 1 for the six cycles that follow the launch edge. A launching control write made while busy is ignored, apart from its R3 effect.
- R7: All five result words change together on the sixth edge after launch, and busy falls on that same edge. Status bit 5 (done) is set on the edge after that.
- R8: The core state is s0..s4, loaded from seed slots 0..4. Each step computes t = s0^(s0>>2), shifts s0..s3 <= s1..s4, and sets s4 <= (s4^(s4<<4))^(t^(t<<1)). Result word k is the new s4 after step k+1.
- R9: If all five seeds are zero, the core loads s0 = 0x2545F491 and s1..s4 = 0 in their place.
- R10: A status write sets bits 5, 4 and 3 to the written values and leaves every other status bit unchanged. If a done event falls on the same edge, bit 5 becomes 1.
- R11: Status bit 0 always reads 1, and bits 6, 7 and 31:8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset in the 0x200 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address during a read |

## Verification
A wrong internal state shows up on the same cycle at the read port. A stuck phase counter shows as busy held too long or too short in the status word. A bad shift or tap in the core changes every result word after the run commits. A seed flag that is lost or set by mistake moves the cycle on which status bit 1 rises. The bench holds a behavioural model that predicts the read data for the current address on every clock, so a fault is seen within a cycle of the first read that reaches the affected register. Directed reads also pin down the exact cycles of the launch, commit and done events.

// File: rtl/seedrng_pkg.sv
package seedrng_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 9;
  localparam int N_WORDS = 5;
  localparam int IDX_W   = $clog2(N_WORDS);
  localparam int PH_W    = $clog2(N_WORDS + 2);
  localparam int SPAN    = 4 * N_WORDS;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_STAT = 9'h010;
  localparam logic [ADDR_W-1:0] OFS_SEED = 9'h140;
  localparam logic [ADDR_W-1:0] OFS_RES  = 9'h160;

  // control bits
  localparam int CB_ENGINE = 3;
  localparam int CB_START  = 4;
  // status bits
  localparam int SB_READY  = 0;
  localparam int SB_SEEDOK = 1;
  localparam int SB_BUSY   = 2;
  localparam int SB_PART   = 3;
  localparam int SB_MSG    = 4;
  localparam int SB_DONE   = 5;
  localparam int SB_ERR    = 7;

  localparam logic [DATA_W-1:0] ZERO_SUBST = 32'h2545_F491;

  typedef enum logic [2:0] {
    RK_NONE, RK_CTRL, RK_STAT, RK_SEED, RK_RES
  } rkind_e;

  typedef struct packed {
    rkind_e           kind;
    logic [IDX_W-1:0] idx;
  } rdec_t;

  typedef logic [N_WORDS-1:0][DATA_W-1:0] wordvec_t;

  function automatic wordvec_t xs_step(input wordvec_t s);
    logic [DATA_W-1:0] t;
    wordvec_t          n;
    t = s[0] ^ (s[0] >> 2);
    for (int i = 0; i < N_WORDS - 1; i++) n[i] = s[i+1];
    n[N_WORDS-1] = (s[N_WORDS-1] ^ (s[N_WORDS-1] << 4)) ^ (t ^ (t << 1));
    return n;
  endfunction
endpackage

// File: rtl/seedrng_decode.sv
module seedrng_decode
  import seedrng_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output rdec_t             dec
);
  logic [ADDR_W-1:0] seed_off;
  logic [ADDR_W-1:0] res_off;

  assign seed_off = addr - OFS_SEED;
  assign res_off  = addr - OFS_RES;

  always_comb begin
    dec.kind = RK_NONE;
    dec.idx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == OFS_CTRL) begin
        dec.kind = RK_CTRL;
      end else if (addr == OFS_STAT) begin
        dec.kind = RK_STAT;
      end else if (addr >= OFS_SEED && seed_off < ADDR_W'(SPAN)) begin
        dec.kind = RK_SEED;
        dec.idx  = seed_off[IDX_W+1:2];
      end else if (addr >= OFS_RES && res_off < ADDR_W'(SPAN)) begin
        dec.kind = RK_RES;
        dec.idx  = res_off[IDX_W+1:2];
      end
    end
  end
endmodule

// File: rtl/seedrng_regs.sv
module seedrng_regs
  import seedrng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  rdec_t             dec,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              done_evt,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] status,
  output wordvec_t          seeds,
  output logic              launch
);
  logic [DATA_W-1:0]  ctrl_q, ctrl_d;
  logic               ctrl_en;
  wordvec_t           seed_q, seed_d;
  logic [N_WORDS-1:0] flag_q, flag_d, seed_hit;
  logic [2:0]         sb_q, sb_d;   // {done, msg, partial}
  logic               seed_ok;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_hit
    assign seed_hit[g] = wr_en && dec.kind == RK_SEED && dec.idx == IDX_W'(g);
  end

  assign seed_ok = &flag_q;
  assign ctrl_en = wr_en && dec.kind == RK_CTRL;
  assign launch  = ctrl_en && seed_ok && wdata[CB_ENGINE] && wdata[CB_START] && !busy;

  always_comb begin
    ctrl_d = wdata & ~(DATA_W'(1) << CB_START);
    seed_d = seed_q;
    flag_d = flag_q;
    for (int i = 0; i < N_WORDS; i++) begin
      if (seed_hit[i]) begin
        seed_d[i] = wdata;
        flag_d[i] = 1'b1;
      end
    end
    sb_d = sb_q;
    if (wr_en && dec.kind == RK_STAT) sb_d = {wdata[SB_DONE], wdata[SB_MSG], wdata[SB_PART]};
    if (done_evt) sb_d[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      seed_q <= '0;
      flag_q <= '0;
      sb_q   <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (|seed_hit) begin
        seed_q <= seed_d;
        flag_q <= flag_d;
      end
      sb_q <= sb_d;
    end
  end

  always_comb begin
    status            = '0;
    status[SB_READY]  = 1'b1;
    status[SB_SEEDOK] = seed_ok;
    status[SB_BUSY]   = busy;
    status[SB_PART]   = sb_q[0];
    status[SB_MSG]    = sb_q[1];
    status[SB_DONE]   = sb_q[2];
  end

  assign ctrl  = ctrl_q;
  assign seeds = seed_q;

  p_start_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> !ctrl_q[CB_START]);
  p_seed_ok_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_ok |=> seed_ok);
  p_done_sets_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> status[SB_DONE]);
endmodule

// File: rtl/seedrng_core.sv
module seedrng_core
  import seedrng_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch,
  input  wordvec_t seeds,
  output logic     busy,
  output logic     done_evt,
  output wordvec_t results
);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(N_WORDS);
  localparam logic [PH_W-1:0] PH_COMMIT = PH_W'(N_WORDS + 1);

  logic [PH_W-1:0] ph_q, ph_d;
  wordvec_t        st_q, st_d, stg_q, stg_d, res_q, start_vec;
  logic            st_en, commit, done_q;

  always_comb begin
    start_vec    = seeds;
    if (seeds == '0) start_vec[0] = ZERO_SUBST;
    ph_d   = ph_q;
    st_d   = st_q;
    stg_d  = stg_q;
    st_en  = 1'b0;
    commit = (ph_q == PH_COMMIT);
    if (ph_q == '0) begin
      if (launch) begin
        st_d  = start_vec;
        st_en = 1'b1;
        ph_d  = PH_W'(1);
      end
    end else if (ph_q <= PH_LAST) begin
      st_d  = xs_step(st_q);
      st_en = 1'b1;
      for (int i = 0; i < N_WORDS; i++)
        if (ph_q == PH_W'(i + 1)) stg_d[i] = st_d[N_WORDS-1];
      ph_d = ph_q + 1'b1;
    end else begin
      ph_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      st_q   <= '0;
      stg_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (st_en) begin
        st_q  <= st_d;
        stg_q <= stg_d;
      end
      if (commit) res_q <= stg_q;
      done_q <= commit;
    end
  end

  assign busy     = (ph_q != '0);
  assign done_evt = done_q;
  assign results  = res_q;

  p_busy_after_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  p_no_launch_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
  p_done_on_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_evt);
  p_results_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(res_q));
endmodule

// File: rtl/seedrng_periph.sv
module seedrng_periph
  import seedrng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  rdec_t             dec;
  logic              wr_en, rd_en, launch, busy, done_evt;
  logic [DATA_W-1:0] ctrl, status;
  wordvec_t          seeds, results;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  seedrng_decode u_dec (.addr(bus_addr), .dec(dec));

  seedrng_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .dec(dec), .wdata(bus_wdata),
    .busy(busy), .done_evt(done_evt), .ctrl(ctrl), .status(status),
    .seeds(seeds), .launch(launch)
  );

  seedrng_core u_core (
    .clk(clk), .rst_n(rst_core_n), .launch(launch), .seeds(seeds),
    .busy(busy), .done_evt(done_evt), .results(results)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (dec.kind)
        RK_CTRL: bus_rdata = ctrl;
        RK_STAT: bus_rdata = status;
        RK_RES:  bus_rdata = results[dec.idx];
        default: bus_rdata = '0;
      endcase
    end
  end

  p_idle_bus_zero_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_en |-> bus_rdata == '0);
endmodule

// File: tb/seedrng_periph_tb_top.sv
`timescale 1ns/1ps
module seedrng_periph_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  seedrng_periph dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
                        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata));

  // ---------------- behavioural model ----------------
  logic [31:0] m_ctrl, m_seed[5], m_res[5], m_stg[5], m_st[5];
  bit          m_flag[5];
  bit [2:0]    m_sb;
  int          m_ph;
  bit          m_dp;

  function automatic bit m_seed_ok();
    for (int i = 0; i < 5; i++) if (!m_flag[i]) return 0;
    return 1;
  endfunction

  task automatic xs_next(inout logic [31:0] s[5]);
    logic [31:0] t, v;
    t = s[0] ^ (s[0] >> 2);
    v = s[4];
    for (int i = 0; i < 4; i++) s[i] = s[i+1];
    s[4] = (v ^ (v << 4)) ^ (t ^ (t << 1));
  endtask

  task automatic ref_gen(input logic [31:0] sd[5], output logic [31:0] o[5]);
    logic [31:0] s[5];
    bit z;
    z = 1;
    for (int i = 0; i < 5; i++) begin s[i] = sd[i]; if (sd[i] != 0) z = 0; end
    if (z) s[0] = 32'h2545_F491;
    for (int k = 0; k < 5; k++) begin xs_next(s); o[k] = s[4]; end
  endtask

  function automatic logic [31:0] m_read(input logic [8:0] a);
    if (!(sel && !wr)) return 32'h0;
    if (a == 9'h000) return m_ctrl;
    if (a == 9'h010) return {24'h0, 2'b00, m_sb, (m_ph != 0), m_seed_ok(), 1'b1};
    if (a >= 9'h160 && a < 9'h174 && a[1:0] == 2'b00) return m_res[(a - 9'h160) >> 2];
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [8:0] a);
    if (a == 9'h000) return "R3";
    if (a == 9'h010) return "R6";
    if (a >= 9'h160 && a < 9'h174) return "R8";
    return "R2";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_sb = 0; m_ph = 0; m_dp = 0;
      for (int i = 0; i < 5; i++) begin
        m_seed[i] = 0; m_res[i] = 0; m_stg[i] = 0; m_st[i] = 0; m_flag[i] = 0;
      end
    end else begin
      bit launch, dp_new, z;
      launch = sel && wr && addr == 9'h000 && m_seed_ok() && wdata[3] && wdata[4] && m_ph == 0;
      dp_new = 0;
      if (m_ph == 0) begin
        if (launch) begin
          z = 1;
          for (int i = 0; i < 5; i++) begin m_st[i] = m_seed[i]; if (m_seed[i] != 0) z = 0; end
          if (z) m_st[0] = 32'h2545_F491;
          m_ph = 1;
        end
      end else if (m_ph <= 5) begin
        xs_next(m_st);
        m_stg[m_ph-1] = m_st[4];
        m_ph++;
      end else begin
        for (int i = 0; i < 5; i++) m_res[i] = m_stg[i];
        m_ph = 0;
        dp_new = 1;
      end
      if (sel && wr) begin
        if (addr == 9'h000) m_ctrl = wdata & ~32'h10;
        else if (addr == 9'h010) m_sb = {wdata[5], wdata[4], wdata[3]};
        else if (addr >= 9'h140 && addr < 9'h154 && addr[1:0] == 2'b00) begin
          m_seed[(addr - 9'h140) >> 2] = wdata;
          m_flag[(addr - 9'h140) >> 2] = 1;
        end
      end
      if (m_dp) m_sb[2] = 1;
      m_dp = dp_new;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      logic [31:0] e;
      e = m_read(addr);
      n_chk++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s model compare addr=%h actual=%h expected=%h", tag_of(addr), addr, rdata, e);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); sel = 0; wr = 0; end
  endtask

  task automatic bwr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic brd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
  endtask

  task automatic rchk(input logic [8:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    brd(a, d);
    chk(d, exp, tag);
  endtask

  initial begin
    logic [31:0] sd[5], zs[5], ex[5];
    sd = '{32'h1234_5678, 32'h9ABC_DEF0, 32'h0BAD_F00D, 32'hCAFE_BABE, 32'h0000_0001};
    zs = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);

    // R1 reset values
    rchk(9'h000, 32'h0, "R1 control");
    rchk(9'h010, 32'h1, "R1 status");
    for (int i = 0; i < 5; i++) rchk(9'(9'h160 + 4*i), 32'h0, "R1 result");

    // R5 no seeds: nothing starts; R3 start bit cleared
    bwr(9'h000, 32'h18); idle(8);
    rchk(9'h000, 32'h8, "R3 start bit cleared");
    rchk(9'h010, 32'h1, "R5 no run without seeds");

    // R2 unmapped
    bwr(9'h004, 32'hFFFF_FFFF);
    rchk(9'h004, 32'h0, "R2 unmapped read");

    // R4 seeds, R2 misaligned and write-only slots
    for (int i = 0; i < 4; i++) bwr(9'(9'h140 + 4*i), sd[i]);
    bwr(9'h152, 32'h5555_5555);
    rchk(9'h010, 32'h1, "R4 four seeds not enough / R2 misaligned ignored");
    rchk(9'h140, 32'h0, "R2 seed reads zero");
    bwr(9'h150, sd[4]);
    rchk(9'h010, 32'h3, "R4 seed-ok set");

    // R5 single-condition writes do not launch
    bwr(9'h000, 32'h10); idle(8);
    rchk(9'h010, 32'h3, "R5 start without engine");
    bwr(9'h000, 32'h08); idle(8);
    rchk(9'h010, 32'h3, "R5 engine without start");

    // launch, R6 busy, R7 commit timing, R8 values
    bwr(9'h000, 32'h118);
    rchk(9'h010, 32'h7, "R6 busy after launch");
    rchk(9'h160, 32'h0, "R7 results unchanged while busy");
    bwr(9'h000, 32'h18);             // ignored relaunch
    idle(8);
    rchk(9'h010, 32'h23, "R7 done set, busy clear");
    ref_gen(sd, ex);
    for (int i = 0; i < 5; i++) rchk(9'(9'h160 + 4*i), ex[i], "R8 result word");
    rchk(9'h000, 32'h8, "R3 last control write kept, start cleared");

    // R10 status writes, R11 fixed bits
    bwr(9'h010, 32'hFFFF_FFFF);
    rchk(9'h010, 32'h3B, "R10/R11 status write mask");
    bwr(9'h010, 32'h0);
    rchk(9'h010, 32'h03, "R10 status clear");

    // R8 determinism
    bwr(9'h000, 32'h18); idle(8);
    for (int i = 0; i < 5; i++) rchk(9'(9'h160 + 4*i), ex[i], "R8 same seeds same words");

    // R10 done event wins over a simultaneous status write
    bwr(9'h010, 32'h0);
    bwr(9'h000, 32'h18);
    idle(5);
    bwr(9'h010, 32'h0);
    rchk(9'h010, 32'h23, "R10 done wins collision");

    // R9 all-zero seeds
    for (int i = 0; i < 5; i++) bwr(9'(9'h140 + 4*i), 32'h0);
    bwr(9'h000, 32'h18); idle(8);
    ref_gen(zs, ex);
    for (int i = 0; i < 5; i++) rchk(9'(9'h160 + 4*i), ex[i], "R9 zero-seed substitution");
    rchk(9'h010, 32'h23, "R11 fixed bits");

    idle(2);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule